// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM. It fetches one word per request. A host raises `rd_start` for a cycle and supplies a word address. The block raises chip select and sends a fixed read command followed by the address. It then clocks in a data word, releases the device and reports the word with a one-cycle `rd_done` strobe.

The serial interface is slow compared with the system clock. Two parameters, counted in system clock cycles, set the timing. `PHASE_CYC` is the length of every high and every low phase of the serial clock. `SETUP_CYC` is the time an outgoing bit is held on the line before the serial clock rises. At 200 MHz the defaults of 1800 and 80 cycles give 9 µs and 0.4 µs. After chip select is released, one extra clock pulse closes the transaction.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset and whenever no read is in progress, `ee_sclk`, `ee_csel`, `ee_to_rom` and `rd_done` are low.
- R2: A start accepted while idle raises `ee_csel` in the next cycle. `ee_to_rom` is then held low and `ee_sclk` low for `SETUP_CYC` cycles before the first command bit is driven.
- R3: The outgoing bits are the 3-bit read command 1,1,0 followed by the `ADDR_W`-bit address latched at start, each sent most significant bit first.
- R4: Each outgoing bit is placed on `ee_to_rom` with `ee_sclk` low for `SETUP_CYC` cycles before `ee_sclk` rises. It stays unchanged through the following high phase and low phase.
- R5: Every high phase of `ee_sclk` lasts exactly `PHASE_CYC` cycles. Every low phase that follows a high phase and comes before the next setup or close step also lasts `PHASE_CYC` cycles.
- R6: After the last address bit, `ee_to_rom` is driven low for `SETUP_CYC` cycles with `ee_sclk` low before input clocking begins.
- R7: Sixteen data bits are read most significant bit first. Each bit is sampled from `ee_from_rom` in the last cycle of its `ee_sclk` high phase.
- R8: After the sixteenth low phase, `ee_csel` and `ee_to_rom` are low together for `SETUP_CYC` cycles. A closing pulse follows: `ee_sclk` is high for `PHASE_CYC` cycles, then low for `PHASE_CYC` cycles.
- R9: `rd_done` is high for exactly one cycle, right after the closing low phase. `rd_word` takes the received word in that cycle and changes at no other time.
- R10: A start raised while a read is in progress has no effect on the waveform, on the latched address or on the returned word.
- R11: A start raised in the cycle where `rd_done` is high is accepted as a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Single-cycle read request |
| rd_addr | input | ADDR_W | Word address, latched when the request is accepted |
| ee_from_rom | input | 1 | Serial data from the EEPROM |
| ee_sclk | output | 1 | Serial clock to the EEPROM |
| ee_csel | output | 1 | Chip select to the EEPROM, active high |
| ee_to_rom | output | 1 | Serial data to the EEPROM |
| rd_done | output | 1 | One-cycle completion strobe |
| rd_word | output | DATA_W | Last word read |

## Verification
A request raised in one cycle shows on `ee_csel` in the next cycle. From then on every segment of the serial waveform lasts a known number of cycles, and `rd_done` falls in the single cycle after the closing low phase. The bench expands each accepted request into a queue with one expected `{ee_csel, ee_sclk, ee_to_rom, rd_done}` entry per cycle. It pops one entry at every falling clock edge and compares it with the outputs. It also checks `rd_word` against the word the bench's own EEPROM model served, both in the done cycle and for stability in every other cycle. Requests sent during a read leave the queue untouched. A request in the done cycle is accepted because the queue is empty at that point.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_OSETUP,
    ST_OHIGH,
    ST_OLOW,
    ST_HOLD,
    ST_IHIGH,
    ST_ILOW,
    ST_CSOFF,
    ST_CHIGH,
    ST_CLOW
  } mw_state_e;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr)     word <= '0;
    else if (shift_en)  word <= {word[WIDTH-2:0], din};
  end
endmodule

// File: rtl/mw_sequencer.sv
module mw_sequencer
  import mw_pkg::*;
#(
  parameter int          PHASE_CYC = 1800,
  parameter int          SETUP_CYC = 80,
  parameter int          OP_W      = 3,
  parameter logic [OP_W-1:0] OPCODE = 3'b110,
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 16,
  parameter int          CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              expired,
  input  logic [DATA_W-1:0] rx_word,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              rx_clr,
  output logic              rx_shift,
  output logic              sclk,
  output logic              csel,
  output logic              to_rom,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  localparam int TXW   = OP_W + ADDR_W;
  localparam int BMAX  = (TXW > DATA_W) ? TXW : DATA_W;
  localparam int BIDXW = $clog2(BMAX);
  localparam logic [CNT_W-1:0] PH_LD = CNT_W'(PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [BIDXW-1:0] TX_LAST = BIDXW'(TXW - 1);
  localparam logic [BIDXW-1:0] RX_LAST = BIDXW'(DATA_W - 1);

  mw_state_e        state;
  logic [TXW-1:0]   txsr;
  logic [BIDXW-1:0] bidx;

  // Segment timer reload: short setup-type segments vs. clock phases.
  always_comb begin
    load     = (state == ST_IDLE) ? start : expired;
    load_val = PH_LD;
    unique case (state)
      ST_IDLE:  load_val = SU_LD;                                  // -> LEAD
      ST_LEAD:  load_val = SU_LD;                                  // -> OSETUP
      ST_OLOW:  load_val = SU_LD;                                  // -> OSETUP/HOLD
      ST_ILOW:  load_val = (bidx == RX_LAST) ? SU_LD : PH_LD;      // -> CSOFF/IHIGH
      default:  load_val = PH_LD;
    endcase
  end

  assign rx_clr   = (state == ST_IDLE) && start;
  assign rx_shift = (state == ST_IHIGH) && expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      txsr   <= '0;
      bidx   <= '0;
      sclk   <= 1'b0;
      csel   <= 1'b0;
      to_rom <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LEAD;
          csel  <= 1'b1;
          txsr  <= {OPCODE, addr};
          bidx  <= '0;
        end
        ST_LEAD: if (expired) begin
          state  <= ST_OSETUP;
          to_rom <= txsr[TXW-1];
        end
        ST_OSETUP: if (expired) begin
          state <= ST_OHIGH;
          sclk  <= 1'b1;
        end
        ST_OHIGH: if (expired) begin
          state <= ST_OLOW;
          sclk  <= 1'b0;
        end
        ST_OLOW: if (expired) begin
          if (bidx == TX_LAST) begin
            state  <= ST_HOLD;
            to_rom <= 1'b0;
            bidx   <= '0;
          end else begin
            state  <= ST_OSETUP;
            bidx   <= bidx + 1'b1;
            txsr   <= txsr << 1;
            to_rom <= txsr[TXW-2];
          end
        end
        ST_HOLD: if (expired) begin
          state <= ST_IHIGH;
          sclk  <= 1'b1;
        end
        ST_IHIGH: if (expired) begin
          state <= ST_ILOW;
          sclk  <= 1'b0;
        end
        ST_ILOW: if (expired) begin
          if (bidx == RX_LAST) begin
            state  <= ST_CSOFF;
            csel   <= 1'b0;
            to_rom <= 1'b0;
          end else begin
            state <= ST_IHIGH;
            bidx  <= bidx + 1'b1;
            sclk  <= 1'b1;
          end
        end
        ST_CSOFF: if (expired) begin
          state <= ST_CHIGH;
          sclk  <= 1'b1;
        end
        ST_CHIGH: if (expired) begin
          state <= ST_CLOW;
          sclk  <= 1'b0;
        end
        ST_CLOW: if (expired) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          word  <= rx_word;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-only counter of consecutive high cycles on sclk.
  logic [CNT_W:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)       hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  // R5
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_cnt == (CNT_W+1)'(PHASE_CYC));

  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(to_rom));

  // R8
  cs_data_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csel) |-> !to_rom && !sclk);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sclk && !csel && !to_rom);
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int PHASE_CYC = 1800,
  parameter int SETUP_CYC = 80,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ee_from_rom,
  output logic              ee_sclk,
  output logic              ee_csel,
  output logic              ee_to_rom,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_word
);
  localparam int OP_W    = 3;
  localparam logic [OP_W-1:0] READ_OP = 3'b110;
  localparam int MAX_LEN = (PHASE_CYC > SETUP_CYC) ? PHASE_CYC : SETUP_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              rx_clr;
  logic              rx_shift;
  logic [DATA_W-1:0] rx_word;

  mw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  mw_rx_shift #(.WIDTH(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .shift_en(rx_shift),
    .din(ee_from_rom), .word(rx_word)
  );

  mw_sequencer #(
    .PHASE_CYC(PHASE_CYC), .SETUP_CYC(SETUP_CYC), .OP_W(OP_W),
    .OPCODE(READ_OP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(rd_start), .addr(rd_addr),
    .expired(tmr_exp), .rx_word(rx_word),
    .load(tmr_load), .load_val(tmr_val), .rx_clr(rx_clr), .rx_shift(rx_shift),
    .sclk(ee_sclk), .csel(ee_csel), .to_rom(ee_to_rom),
    .done(rd_done), .word(rd_word)
  );

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_word) |-> rd_done);
endmodule

// File: tb/mw_eeprom_reader_test.sv
`timescale 1ns/1ps
module mw_eeprom_reader_test;
  localparam int PH = 4;
  localparam int SU = 2;
  localparam int AW = 6;
  localparam int DW = 16;

  typedef struct {
    logic cs, sk, di, dn;
    logic upd;
    logic [DW-1:0] w;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic ee_from_rom = 1'b0;
  logic ee_sclk, ee_csel, ee_to_rom, rd_done;
  logic [DW-1:0] rd_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t q[$];
  logic [DW-1:0] exp_word = '0;

  always #2.5 clk = ~clk;

  mw_eeprom_reader #(.PHASE_CYC(PH), .SETUP_CYC(SU), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_addr(rd_addr),
    .ee_from_rom(ee_from_rom), .ee_sclk(ee_sclk), .ee_csel(ee_csel),
    .ee_to_rom(ee_to_rom), .rd_done(rd_done), .rd_word(rd_word)
  );

  function automatic logic [DW-1:0] rom_of(input logic [AW-1:0] a);
    return (DW'(a) * 16'h1357) ^ 16'hA5C3;
  endfunction

  // Behavioural EEPROM: collects 9 command bits, then serves the word.
  int rc = 0;
  logic [8:0] cmd = '0;
  logic [DW-1:0] srv = '0;
  always @(posedge ee_sclk) begin
    if (!ee_csel) rc = 0;
    else begin
      if (rc < 9) begin
        cmd = {cmd[7:0], ee_to_rom};
        if (rc == 8) srv = (cmd[8:6] == 3'b110) ? rom_of(cmd[5:0]) : 16'h0000;
      end else if (rc < 9 + DW) ee_from_rom = srv[DW-1-(rc-9)];
      rc = rc + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cycles, act, exp);
    end
  endtask

  task automatic seg(input int n, input logic cs, input logic sk, input logic di, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cs = cs; e.sk = sk; e.di = di; e.dn = 1'b0; e.upd = 1'b0; e.w = '0; e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic build(input logic [AW-1:0] a);
    logic [8:0] tx;
    exp_t e;
    tx = {3'b110, a};
    seg(SU, 1, 0, 0, "R2");
    for (int b = 8; b >= 0; b--) begin
      seg(SU, 1, 0, tx[b], "R4");
      seg(PH, 1, 1, tx[b], "R5");
      seg(PH, 1, 0, tx[b], "R3");
    end
    seg(SU, 1, 0, 0, "R6");
    for (int k = 0; k < DW; k++) begin
      seg(PH, 1, 1, 0, "R7");
      seg(PH, 1, 0, 0, "R7");
    end
    seg(SU, 0, 0, 0, "R8");
    seg(PH, 0, 1, 0, "R8");
    seg(PH, 0, 0, 0, "R8");
    e.cs = 0; e.sk = 0; e.di = 0; e.dn = 1; e.upd = 1; e.w = rom_of(a); e.req = "R9";
    q.push_back(e);
  endtask

  // One clock: compare at the falling edge against the model.
  task automatic step();
    exp_t e;
    @(negedge clk);
    cycles++;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.cs = 0; e.sk = 0; e.di = 0; e.dn = 0; e.upd = 0; e.w = '0; e.req = "R1";
    end
    if (e.upd) exp_word = e.w;
    check(ee_csel == e.cs, e.req, "ee_csel", 32'(ee_csel), 32'(e.cs));
    check(ee_sclk == e.sk, e.req, "ee_sclk", 32'(ee_sclk), 32'(e.sk));
    check(ee_to_rom == e.di, e.req, "ee_to_rom", 32'(ee_to_rom), 32'(e.di));
    check(rd_done == e.dn, "R9", "rd_done", 32'(rd_done), 32'(e.dn));
    check(rd_word == exp_word, e.upd ? "R7" : "R9", "rd_word", 32'(rd_word), 32'(exp_word));
  endtask

  task automatic issue(input logic [AW-1:0] a);
    rd_start = 1'b1; rd_addr = a;
    build(a);
    step();
    rd_start = 1'b0; rd_addr = ~a;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  initial begin
    int guard;
    guard = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!ee_sclk && !ee_csel && !ee_to_rom && !rd_done, "R1", "idle outputs",
          {28'd0, ee_sclk, ee_csel, ee_to_rom, rd_done}, 32'd0);
    check(rd_word == '0, "R1", "rd_word after reset", 32'(rd_word), 32'd0);
    repeat (3) step();

    // Address zero, all-ones address, alternating pattern
    issue(6'h00); drain(); repeat (2) step();
    check(rd_word == rom_of(6'h00), "R3", "word for address 0", 32'(rd_word), 32'(rom_of(6'h00)));
    issue(6'h3F); drain(); repeat (2) step();
    check(rd_word == rom_of(6'h3F), "R3", "word for address 63", 32'(rd_word), 32'(rom_of(6'h3F)));

    // R10: requests during a read are ignored
    issue(6'h2A);
    repeat (20) step();
    rd_start = 1'b1; rd_addr = 6'h15;
    step();
    rd_start = 1'b0;
    repeat (150) step();
    rd_start = 1'b1; rd_addr = 6'h01;
    step();
    rd_start = 1'b0;
    drain(); repeat (2) step();
    check(rd_word == rom_of(6'h2A), "R10", "word after ignored start", 32'(rd_word), 32'(rom_of(6'h2A)));

    // R11: back-to-back request in the done cycle
    issue(6'h15); drain();
    issue(6'h2B); drain(); repeat (3) step();
    check(rd_word == rom_of(6'h2B), "R11", "back-to-back word", 32'(rd_word), 32'(rom_of(6'h2B)));
    check(!ee_csel && !ee_sclk, "R1", "idle after reads", {30'd0, ee_csel, ee_sclk}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule